// File: doc/BRIEF.md
# Extension Instruction Handle Dispatcher

This unit sits beside a processor core and gives software a uniform way to reach optional hardware through eight generic control instructions. Before software can use a device it issues an open request with a 20-bit interface identifier. The unit searches the attached devices for that identifier and reserves a free handle slot. It asks the device to initialise and stores three things in the slot: which device answered, the address-space ID of the caller, and the cookie the device returned. The handle comes back to software as the slot number placed at bit 12 of a 32-bit value.

Control requests carry the handle in the rs1 operand. The unit validates the handle against the table and against the caller's address space. It checks that the bound device implements the selected control number, then forwards the request to that device with the stored cookie. A close request asks the device to shut down. The slot is freed only if the device reports no error. A handle used from a foreign address space is rejected exactly as if the slot were empty, so other address spaces cannot detect that it exists.

Each device sits behind a valid/ready request channel and a one-cycle response strobe. Only one request is in flight at a time.

Top module: `ext_dispatch`

## Requirements
- R1: An open request (op code 0) whose identifier matches an attached device takes the lowest-numbered free slot and sends that device an initialise request. When the response arrives, done pulses with cause 0, result holds the device's returned cookie and handle holds the slot number shifted left by 12. When several devices match, the lowest-indexed one wins.
- R2: An open whose identifier matches no attached device finishes with cause 1 (no interface) and result 0. It allocates no slot and sends nothing to any device.
- R3: An open with a known identifier while all 16 slots are occupied finishes with cause 3 (table full). An unknown identifier reports cause 1 even when the table is full.
- R4: The slot number of a handle is rs1 bits 15:12. Bits 11:0 of rs1 never change the outcome. Any rs1 whose value shifted right by 12 is 16 or more counts as an empty slot.
- R5: A control request (op code 2) or a close on an empty slot, or on a slot opened from a different address-space ID, sends no device request. A control request in this case finishes with cause 1. A close in this case finishes with cause 0 and result all ones.
- R6: A control request on a valid slot whose device does not implement the selected control number (0 to 7) finishes with cause 2 (no instruction) and sends nothing to the device.
- R7: A valid control request goes only to the bound device, with kind code 2, the control number, instruction bits 31:7, the data operand and the stored cookie. The device's response data becomes the result, with cause 0. The kind codes are 0 for initialise, 1 for shutdown and 2 for control.
- R8: Closing a valid slot (op code 1) whose device has no shutdown routine frees the slot without contacting the device and returns result 0 with cause 0.
- R9: Closing a valid slot whose device has a shutdown routine sends it a shutdown request with the stored cookie. A nonzero error from the device is returned as the result and the slot stays open.
- R10: A shutdown that returns error 0 frees the slot and the close returns 0. The freed slot is then reused by the next open.
- R11: A new request is accepted only while ready is high, and ready stays low until done. Only one device request valid is high at a time, and it is held until that device is ready. Done lasts exactly one cycle.
- R12: Reset empties every slot, raises ready and holds done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request from the core |
| req_ready_o | output | 1 | Unit idle and able to take a request |
| req_op_i | input | 2 | 0 open, 1 close, 2 control |
| req_ctl_i | input | 3 | Control number for op 2 |
| req_fields_i | input | 25 | Instruction bits 31:7 |
| req_id_i | input | 20 | Interface identifier for open |
| req_rs1_i | input | 32 | Handle operand |
| req_data_i | input | 32 | Data operand |
| cur_asid_i | input | 8 | Address-space ID of the caller |
| done_o | output | 1 | One-cycle completion pulse |
| cause_o | output | 2 | 0 none, 1 no interface, 2 no instruction, 3 table full |
| result_o | output | 32 | Result value |
| handle_o | output | 32 | Handle from a successful open, else 0 |
| dev_ids_i | input | 40 | Identifier of each device, 20 bits each |
| dev_ctl_mask_i | input | 16 | Implemented control numbers, 8 bits per device |
| dev_has_shut_i | input | 2 | Device has a shutdown routine |
| dev_req_valid_o | output | 2 | Request valid, one bit per device |
| dev_req_ready_i | input | 2 | Device ready, one bit per device |
| dev_req_kind_o | output | 2 | 0 initialise, 1 shutdown, 2 control |
| dev_req_ctl_o | output | 3 | Control number |
| dev_req_fields_o | output | 25 | Instruction bits 31:7 |
| dev_req_data_o | output | 32 | Data operand |
| dev_req_cookie_o | output | 32 | Cookie stored for the slot |
| dev_rsp_valid_i | input | 2 | Response strobe, one bit per device |
| dev_rsp_data_i | input | 64 | Response data, 32 bits per device |
| dev_rsp_err_i | input | 64 | Response error, 32 bits per device |

## Verification
Directed sequences cover the cases a plain open-then-control flow would never reach:
- Open attempts with an unknown identifier tell "no interface" apart from "table full".
- Controls issued from the wrong address space, on empty slots and on out-of-range handles must look the same to the caller.
- Control numbers a device lacks must give "no instruction".
- A close is tried with a failing shutdown, with a successful one, and on a device with no shutdown routine, and the next open must reuse the freed slot.

Random sequences then mix opens, closes and controls over two address spaces. They use random low handle bits, random device stalls and random shutdown errors, and each result is compared against a table model kept in the bench. The bench also counts device requests, so rejected calls that still reach a device are caught.

// File: rtl/ext_pkg.sv
package ext_pkg;

  typedef enum logic [1:0] {
    OP_OPEN  = 2'd0,
    OP_CLOSE = 2'd1,
    OP_CTL   = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_NO_IF    = 2'd1,
    CAUSE_NO_INSTR = 2'd2,
    CAUSE_FULL     = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    DK_INIT = 2'd0,
    DK_SHUT = 2'd1,
    DK_CTL  = 2'd2
  } dev_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECIDE = 2'd1,
    ST_REQ    = 2'd2,
    ST_RSP    = 2'd3
  } state_e;

endpackage

// File: rtl/ext_dev_match.sv
module ext_dev_match #(
  parameter int NDEV  = 2,
  parameter int ID_W  = 20,
  parameter int DEV_W = 1
) (
  input  logic [NDEV*ID_W-1:0] dev_ids_i,
  input  logic [ID_W-1:0]      id_i,
  output logic                 hit_o,
  output logic [DEV_W-1:0]     idx_o
);

  logic [NDEV-1:0] eq;

  for (genvar g = 0; g < NDEV; g++) begin : g_cmp
    assign eq[g] = (dev_ids_i[g*ID_W +: ID_W] == id_i);
  end

  // lowest-indexed device wins when several share an identifier
  function automatic logic [DEV_W-1:0] first_hit(input logic [NDEV-1:0] v);
    logic [DEV_W-1:0] r;
    r = '0;
    for (int i = NDEV - 1; i >= 0; i--) begin
      if (v[i]) r = DEV_W'(i);
    end
    return r;
  endfunction

  assign hit_o = |eq;
  assign idx_o = first_hit(eq);

endmodule

// File: rtl/ext_handle_table.sv
module ext_handle_table #(
  parameter int NSLOT  = 16,
  parameter int SLOT_W = 4,
  parameter int DEV_W  = 1,
  parameter int ASID_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] rd_idx_i,
  output logic              rd_valid_o,
  output logic [DEV_W-1:0]  rd_dev_o,
  output logic [ASID_W-1:0] rd_asid_o,
  output logic [DATA_W-1:0] rd_cookie_o,
  input  logic              alloc_we_i,
  input  logic [SLOT_W-1:0] alloc_idx_i,
  input  logic [DEV_W-1:0]  alloc_dev_i,
  input  logic [ASID_W-1:0] alloc_asid_i,
  input  logic [DATA_W-1:0] alloc_cookie_i,
  input  logic              clear_we_i,
  input  logic [SLOT_W-1:0] clear_idx_i,
  output logic              free_hit_o,
  output logic [SLOT_W-1:0] free_idx_o
);

  logic [NSLOT-1:0]  vld_q;
  logic [DEV_W-1:0]  dev_q    [NSLOT];
  logic [ASID_W-1:0] asid_q   [NSLOT];
  logic [DATA_W-1:0] cookie_q [NSLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        dev_q[i]    <= '0;
        asid_q[i]   <= '0;
        cookie_q[i] <= '0;
      end
    end else begin
      if (alloc_we_i) begin
        vld_q[alloc_idx_i]    <= 1'b1;
        dev_q[alloc_idx_i]    <= alloc_dev_i;
        asid_q[alloc_idx_i]   <= alloc_asid_i;
        cookie_q[alloc_idx_i] <= alloc_cookie_i;
      end
      if (clear_we_i) vld_q[clear_idx_i] <= 1'b0;
    end
  end

  function automatic logic [SLOT_W:0] lowest_free(input logic [NSLOT-1:0] v);
    logic [SLOT_W:0] r;
    r = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!v[i]) r = {1'b1, SLOT_W'(i)};
    end
    return r;
  endfunction

  logic [SLOT_W:0] free_sel;
  assign free_sel    = lowest_free(vld_q);
  assign free_hit_o  = free_sel[SLOT_W];
  assign free_idx_o  = free_sel[SLOT_W-1:0];

  assign rd_valid_o  = vld_q[rd_idx_i];
  assign rd_dev_o    = dev_q[rd_idx_i];
  assign rd_asid_o   = asid_q[rd_idx_i];
  assign rd_cookie_o = cookie_q[rd_idx_i];

  // R1: a new binding never lands on an occupied slot
  a_r1_alloc_into_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_we_i |-> !vld_q[alloc_idx_i]);

  // R10: only a live slot is released
  a_r10_clear_live: assert property (@(posedge clk) disable iff (!rst_n)
    clear_we_i |-> vld_q[clear_idx_i]);

  // R11: allocation and release never coincide with one request in flight
  a_r11_single_update: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_we_i && clear_we_i));

endmodule

// File: rtl/ext_dispatch.sv
module ext_dispatch
  import ext_pkg::*;
#(
  parameter int NDEV   = 2,
  parameter int NSLOT  = 16,
  parameter int NCTL   = 8,
  parameter int ID_W   = 20,
  parameter int ASID_W = 8,
  parameter int DATA_W = 32,
  parameter int FLD_W  = 25,
  parameter int HOFF   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic [1:0]                 req_op_i,
  input  logic [$clog2(NCTL)-1:0]    req_ctl_i,
  input  logic [FLD_W-1:0]           req_fields_i,
  input  logic [ID_W-1:0]            req_id_i,
  input  logic [DATA_W-1:0]          req_rs1_i,
  input  logic [DATA_W-1:0]          req_data_i,
  input  logic [ASID_W-1:0]          cur_asid_i,
  output logic                       done_o,
  output logic [1:0]                 cause_o,
  output logic [DATA_W-1:0]          result_o,
  output logic [DATA_W-1:0]          handle_o,
  input  logic [NDEV*ID_W-1:0]       dev_ids_i,
  input  logic [NDEV*NCTL-1:0]       dev_ctl_mask_i,
  input  logic [NDEV-1:0]            dev_has_shut_i,
  output logic [NDEV-1:0]            dev_req_valid_o,
  input  logic [NDEV-1:0]            dev_req_ready_i,
  output logic [1:0]                 dev_req_kind_o,
  output logic [$clog2(NCTL)-1:0]    dev_req_ctl_o,
  output logic [FLD_W-1:0]           dev_req_fields_o,
  output logic [DATA_W-1:0]          dev_req_data_o,
  output logic [DATA_W-1:0]          dev_req_cookie_o,
  input  logic [NDEV-1:0]            dev_rsp_valid_i,
  input  logic [NDEV*DATA_W-1:0]     dev_rsp_data_i,
  input  logic [NDEV*DATA_W-1:0]     dev_rsp_err_i
);

  localparam int SLOT_W = $clog2(NSLOT);
  localparam int CTL_W  = $clog2(NCTL);
  localparam int DEV_W  = (NDEV > 1) ? $clog2(NDEV) : 1;

  // handle arithmetic: slot number lives at bit HOFF of the operand
  function automatic logic [SLOT_W-1:0] slot_of(input logic [DATA_W-1:0] v);
    return v[HOFF +: SLOT_W];
  endfunction

  function automatic logic handle_in_range(input logic [DATA_W-1:0] v);
    return (v >> HOFF) < DATA_W'(NSLOT);
  endfunction

  function automatic logic [DATA_W-1:0] handle_of(input logic [SLOT_W-1:0] s);
    return DATA_W'(s) << HOFF;
  endfunction

  state_e            st_q;
  op_e               op_q;
  logic [CTL_W-1:0]  ctl_q;
  logic [FLD_W-1:0]  fields_q;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] rs1_q, data_q, cookie_q;
  logic [ASID_W-1:0] asid_q;
  dev_kind_e         kind_q;
  logic [DEV_W-1:0]  tgt_dev_q;
  logic [SLOT_W-1:0] tgt_slot_q;
  logic              done_q;
  cause_e            cause_q;
  logic [DATA_W-1:0] result_q, handle_q;

  // named internal events
  logic              ev_accept, ev_dev_fire, ev_rsp, ev_shut_ok;
  logic              match_hit;
  logic [DEV_W-1:0]  match_idx;
  logic              rd_valid;
  logic [DEV_W-1:0]  rd_dev;
  logic [ASID_W-1:0] rd_asid;
  logic [DATA_W-1:0] rd_cookie;
  logic              free_hit;
  logic [SLOT_W-1:0] free_idx;
  logic              slot_ok, ctl_impl, shut_impl;
  logic [NCTL-1:0]   dev_caps;
  logic [DATA_W-1:0] rsp_data, rsp_err;
  logic              alloc_we, clear_we;

  logic              dec_go, dec_clear;
  cause_e            dec_cause;
  logic [DATA_W-1:0] dec_result;
  dev_kind_e         dec_kind;
  logic [DEV_W-1:0]  dec_dev;

  ext_dev_match #(.NDEV(NDEV), .ID_W(ID_W), .DEV_W(DEV_W)) u_match (
    .dev_ids_i (dev_ids_i),
    .id_i      (id_q),
    .hit_o     (match_hit),
    .idx_o     (match_idx)
  );

  ext_handle_table #(
    .NSLOT(NSLOT), .SLOT_W(SLOT_W), .DEV_W(DEV_W), .ASID_W(ASID_W), .DATA_W(DATA_W)
  ) u_table (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_idx_i       (slot_of(rs1_q)),
    .rd_valid_o     (rd_valid),
    .rd_dev_o       (rd_dev),
    .rd_asid_o      (rd_asid),
    .rd_cookie_o    (rd_cookie),
    .alloc_we_i     (alloc_we),
    .alloc_idx_i    (tgt_slot_q),
    .alloc_dev_i    (tgt_dev_q),
    .alloc_asid_i   (asid_q),
    .alloc_cookie_i (rsp_data),
    .clear_we_i     (clear_we),
    .clear_idx_i    (slot_of(rs1_q)),
    .free_hit_o     (free_hit),
    .free_idx_o     (free_idx)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign ev_accept   = req_valid_i && req_ready_o;
  assign ev_dev_fire = |(dev_req_valid_o & dev_req_ready_i);

  // foreign address space looks identical to an empty slot
  assign slot_ok   = handle_in_range(rs1_q) && rd_valid && (rd_asid == asid_q);
  assign dev_caps  = dev_ctl_mask_i[int'(rd_dev)*NCTL +: NCTL];
  assign ctl_impl  = dev_caps[ctl_q];
  assign shut_impl = dev_has_shut_i[rd_dev];

  assign ev_rsp     = (st_q == ST_RSP) && dev_rsp_valid_i[tgt_dev_q];
  assign rsp_data   = dev_rsp_data_i[int'(tgt_dev_q)*DATA_W +: DATA_W];
  assign rsp_err    = dev_rsp_err_i[int'(tgt_dev_q)*DATA_W +: DATA_W];
  assign ev_shut_ok = ev_rsp && (kind_q == DK_SHUT) && (rsp_err == '0);

  always_comb begin
    dec_go     = 1'b0;
    dec_clear  = 1'b0;
    dec_cause  = CAUSE_NONE;
    dec_result = '0;
    dec_kind   = DK_CTL;
    dec_dev    = rd_dev;
    unique case (op_q)
      OP_OPEN: begin
        dec_kind = DK_INIT;
        dec_dev  = match_idx;
        if (!match_hit)     dec_cause = CAUSE_NO_IF;
        else if (!free_hit) dec_cause = CAUSE_FULL;
        else                dec_go    = 1'b1;
      end
      OP_CLOSE: begin
        dec_kind = DK_SHUT;
        if (!slot_ok)        dec_result = '1;
        else if (!shut_impl) dec_clear  = 1'b1;
        else                 dec_go     = 1'b1;
      end
      OP_CTL: begin
        if (!slot_ok)       dec_cause = CAUSE_NO_IF;
        else if (!ctl_impl) dec_cause = CAUSE_NO_INSTR;
        else                dec_go    = 1'b1;
      end
      default: dec_cause = CAUSE_NO_IF;
    endcase
  end

  assign alloc_we = ev_rsp && (kind_q == DK_INIT);
  assign clear_we = ((st_q == ST_DECIDE) && dec_clear) || ev_shut_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      op_q       <= OP_OPEN;
      ctl_q      <= '0;
      fields_q   <= '0;
      id_q       <= '0;
      rs1_q      <= '0;
      data_q     <= '0;
      asid_q     <= '0;
      cookie_q   <= '0;
      kind_q     <= DK_INIT;
      tgt_dev_q  <= '0;
      tgt_slot_q <= '0;
      done_q     <= 1'b0;
      cause_q    <= CAUSE_NONE;
      result_q   <= '0;
      handle_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (ev_accept) begin
          op_q     <= op_e'(req_op_i);
          ctl_q    <= req_ctl_i;
          fields_q <= req_fields_i;
          id_q     <= req_id_i;
          rs1_q    <= req_rs1_i;
          data_q   <= req_data_i;
          asid_q   <= cur_asid_i;
          st_q     <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (dec_go) begin
            tgt_dev_q  <= dec_dev;
            tgt_slot_q <= free_idx;
            kind_q     <= dec_kind;
            cookie_q   <= (dec_kind == DK_INIT) ? '0 : rd_cookie;
            st_q       <= ST_REQ;
          end else begin
            done_q   <= 1'b1;
            cause_q  <= dec_cause;
            result_q <= dec_result;
            handle_q <= '0;
            st_q     <= ST_IDLE;
          end
        end
        ST_REQ: if (ev_dev_fire) st_q <= ST_RSP;
        ST_RSP: if (ev_rsp) begin
          done_q   <= 1'b1;
          cause_q  <= CAUSE_NONE;
          st_q     <= ST_IDLE;
          result_q <= (kind_q == DK_SHUT) ? rsp_err : rsp_data;
          handle_q <= (kind_q == DK_INIT) ? handle_of(tgt_slot_q) : '0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NDEV; g++) begin : g_dev_valid
    assign dev_req_valid_o[g] = (st_q == ST_REQ) && (tgt_dev_q == DEV_W'(g));
  end

  assign dev_req_kind_o   = kind_q;
  assign dev_req_ctl_o    = ctl_q;
  assign dev_req_fields_o = fields_q;
  assign dev_req_data_o   = data_q;
  assign dev_req_cookie_o = cookie_q;

  assign done_o   = done_q;
  assign cause_o  = cause_q;
  assign result_o = result_q;
  assign handle_o = handle_q;

  // R11: at most one device addressed at once
  a_r11_one_device: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_req_valid_o));

  // R11: the core side is closed while a device request is pending
  a_r11_busy_while_dev: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_req_valid_o) |-> !req_ready_o);

  // R11: a stalled device request keeps its target and payload
  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dev_req_valid_o) && !ev_dev_fire) |=>
      ($stable(dev_req_valid_o) && $stable(dev_req_cookie_o) && $stable(dev_req_kind_o)));

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3: table full is reported only when the table really has no free slot
  a_r3_full_real: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cause_o == CAUSE_FULL) |-> !free_hit);

  // R5: a rejected call was never offered to a device the cycle before
  a_r5_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cause_o != CAUSE_NONE) |-> ($past(dev_req_valid_o) == '0));

endmodule

// File: tb/sim_ext_dispatch.sv
`timescale 1ns/1ps
module sim_ext_dispatch;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [2:0]  req_ctl = '0;
  logic [24:0] req_fields = '0;
  logic [19:0] req_id = '0;
  logic [31:0] req_rs1 = '0, req_data = '0;
  logic [7:0]  cur_asid = '0;
  logic        done;
  logic [1:0]  cause;
  logic [31:0] result, handle;

  localparam logic [19:0] ID_A = 20'h0ABCD;
  localparam logic [19:0] ID_B = 20'h01234;
  localparam logic [19:0] ID_X = 20'h77777;
  localparam logic [7:0]  MASK_A = 8'b0000_0011;
  localparam logic [7:0]  MASK_B = 8'b1000_0001;

  logic [1:0]  dv, dr, rv;
  logic [1:0]  dkind;
  logic [2:0]  dctl;
  logic [24:0] dfields;
  logic [31:0] ddata, dcookie;
  logic [31:0] rsp_d [2];
  logic [31:0] rsp_e [2];
  logic [31:0] shut_err [2];

  ext_dispatch u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_ctl_i(req_ctl), .req_fields_i(req_fields), .req_id_i(req_id),
    .req_rs1_i(req_rs1), .req_data_i(req_data), .cur_asid_i(cur_asid),
    .done_o(done), .cause_o(cause), .result_o(result), .handle_o(handle),
    .dev_ids_i({ID_B, ID_A}), .dev_ctl_mask_i({MASK_B, MASK_A}), .dev_has_shut_i(2'b01),
    .dev_req_valid_o(dv), .dev_req_ready_i(dr), .dev_req_kind_o(dkind),
    .dev_req_ctl_o(dctl), .dev_req_fields_o(dfields), .dev_req_data_o(ddata),
    .dev_req_cookie_o(dcookie), .dev_rsp_valid_i(rv),
    .dev_rsp_data_i({rsp_d[1], rsp_d[0]}), .dev_rsp_err_i({rsp_e[1], rsp_e[0]})
  );

  int checks = 0;
  int errors = 0;
  int dev_accepts = 0;

  // device behaviour, restated independently (R7 kind codes)
  function automatic logic [31:0] dev_fn(input int d, input logic [1:0] k, input logic [2:0] c,
                                         input logic [24:0] f, input logic [31:0] ck,
                                         input logic [31:0] dat);
    if (k == 2'd0) return (dat ^ 32'hC0DE_0000) + 32'(d * 16'h0101);
    return (ck ^ {4'(c), 3'b0, f}) + dat + 32'(d);
  endfunction

  logic        pend [2];
  int          wait_n [2];
  logic [31:0] res_n [2], err_n [2];

  // device models act on negative edges so the unit samples them at the next rising edge
  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      rv[d] = 1'b0;
      if (!rst_n) begin
        dr[d] = 1'b0; pend[d] = 1'b0; wait_n[d] = 0; rsp_d[d] = '0; rsp_e[d] = '0;
      end else begin
        dr[d] = ($urandom % 3) != 0;
        if (dv[d] && dr[d]) begin
          pend[d] = 1'b1;
          wait_n[d] = $urandom % 4;
          res_n[d] = dev_fn(d, dkind, dctl, dfields, dcookie, ddata);
          err_n[d] = (dkind == 2'd1) ? shut_err[d] : 32'd0;
          dev_accepts++;
        end else if (pend[d]) begin
          if (wait_n[d] == 0) begin
            pend[d] = 1'b0; rv[d] = 1'b1; rsp_d[d] = res_n[d]; rsp_e[d] = err_n[d];
          end else wait_n[d]--;
        end
      end
    end
  end

  // table model
  logic        m_v [16];
  int          m_dev [16];
  logic [7:0]  m_asid [16];
  logic [31:0] m_ck [16];

  task automatic model_clear();
    for (int i = 0; i < 16; i++) begin m_v[i] = 1'b0; m_dev[i] = 0; m_asid[i] = '0; m_ck[i] = '0; end
  endtask

  function automatic int dev_of(input logic [19:0] id);
    if (id == ID_A) return 0;
    if (id == ID_B) return 1;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
    chk(req_ready === 1'b1, "R12", "ready after reset", 32'(req_ready), 1);
    chk(done === 1'b0, "R12", "done after reset", 32'(done), 0);
  endtask

  // issue one request and compare against the model
  task automatic op(input logic [1:0] o, input logic [2:0] c, input logic [24:0] f,
                    input logic [19:0] id, input logic [31:0] rs1, input logic [31:0] dat,
                    input logic [7:0] asid, input string rq);
    logic [1:0]  e_c;
    logic [31:0] e_r, e_h;
    int e_acc, acc0, n, s, d;
    bit ok;
    e_c = 2'd0; e_r = '0; e_h = '0; e_acc = 0;
    s = int'(rs1 >> 12);
    ok = (s < 16) && m_v[s % 16] && (m_asid[s % 16] == asid);
    if (o == 2'd0) begin
      d = dev_of(id);
      if (d < 0) e_c = 2'd1;
      else begin
        s = -1;
        for (int i = 15; i >= 0; i--) if (!m_v[i]) s = i;
        if (s < 0) e_c = 2'd3;
        else begin
          e_r = dev_fn(d, 2'd0, c, f, 32'd0, dat); e_h = 32'(s) << 12; e_acc = 1;
          m_v[s] = 1'b1; m_dev[s] = d; m_asid[s] = asid; m_ck[s] = e_r;
        end
      end
    end else if (o == 2'd1) begin
      if (!ok) e_r = '1;
      else if (m_dev[s] == 0) begin
        e_acc = 1; e_r = shut_err[0];
        if (shut_err[0] == 0) m_v[s] = 1'b0;
      end else m_v[s] = 1'b0;
    end else begin
      if (!ok) e_c = 2'd1;
      else if (!((m_dev[s] == 0 ? MASK_A : MASK_B) >> c & 8'd1)) e_c = 2'd2;
      else begin e_acc = 1; e_r = dev_fn(m_dev[s], 2'd2, c, f, m_ck[s], dat); end
    end
    acc0 = dev_accepts;
    @(negedge clk);
    req_valid = 1'b1; req_op = o; req_ctl = c; req_fields = f; req_id = id;
    req_rs1 = rs1; req_data = dat; cur_asid = asid;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    if (n >= 100) begin
      chk(1'b0, "R11", "no done", 32'(n), 0);
    end else begin
      chk(cause === e_c, rq, "cause", 32'(cause), 32'(e_c));
      chk(result === e_r, rq, "result", result, e_r);
      chk(handle === e_h, rq, "handle", handle, e_h);
      chk((dev_accepts - acc0) == e_acc, rq, "device requests", 32'(dev_accepts - acc0), 32'(e_acc));
      @(negedge clk);
      chk(done === 1'b0 && req_ready === 1'b1, "R11", "done pulse width", 32'(done), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    shut_err[0] = 0; shut_err[1] = 0;
    model_clear();
    do_reset();

    // R1 opens on both devices, R2 unknown identifier
    op(2'd0, 3'd0, 25'h0, ID_A, 32'h0, 32'h11, 8'd1, "R1");
    op(2'd0, 3'd0, 25'h0, ID_B, 32'h0, 32'h22, 8'd1, "R1");
    op(2'd0, 3'd0, 25'h0, ID_X, 32'h0, 32'h33, 8'd1, "R2");
    // R7 forwarded controls, R4 low bits of rs1 ignored
    op(2'd2, 3'd1, 25'h1ABCDEF, 20'h0, 32'h0000_0ABC, 32'h55, 8'd1, "R7");
    op(2'd2, 3'd7, 25'h0123456, 20'h0, 32'h0000_1FFF, 32'h66, 8'd1, "R4");
    // R6 control not implemented
    op(2'd2, 3'd5, 25'h0, 20'h0, 32'h0000_0000, 32'h0, 8'd1, "R6");
    // R5 foreign address space, empty slot, out-of-range handle
    op(2'd2, 3'd0, 25'h0, 20'h0, 32'h0000_0000, 32'h0, 8'd2, "R5");
    op(2'd2, 3'd0, 25'h0, 20'h0, 32'h0000_9000, 32'h0, 8'd1, "R5");
    op(2'd2, 3'd0, 25'h0, 20'h0, 32'h0001_0000, 32'h0, 8'd1, "R4");
    op(2'd1, 3'd0, 25'h0, 20'h0, 32'h0000_0000, 32'h0, 8'd2, "R5");
    // R9 failing shutdown keeps the slot
    shut_err[0] = 32'd5;
    op(2'd1, 3'd0, 25'h0, 20'h0, 32'h0000_0000, 32'h0, 8'd1, "R9");
    op(2'd2, 3'd0, 25'h0, 20'h0, 32'h0000_0000, 32'h7, 8'd1, "R9");
    // R10 successful shutdown frees and reuses the slot
    shut_err[0] = 32'd0;
    op(2'd1, 3'd0, 25'h0, 20'h0, 32'h0000_0000, 32'h0, 8'd1, "R10");
    op(2'd2, 3'd0, 25'h0, 20'h0, 32'h0000_0000, 32'h0, 8'd1, "R10");
    op(2'd0, 3'd0, 25'h0, ID_B, 32'h0, 32'h44, 8'd2, "R10");
    // R8 close without shutdown routine
    op(2'd1, 3'd0, 25'h0, 20'h0, 32'h0000_1000, 32'h0, 8'd1, "R8");
    // R3 fill the table
    for (int i = 0; i < 15; i++) op(2'd0, 3'd0, 25'h0, ID_A, 32'h0, 32'(i), 8'd1, "R1");
    op(2'd0, 3'd0, 25'h0, ID_A, 32'h0, 32'h9, 8'd1, "R3");
    op(2'd0, 3'd0, 25'h0, ID_X, 32'h0, 32'h9, 8'd1, "R3");

    // random mix against the model
    for (int k = 0; k < 400; k++) begin
      logic [1:0] o; logic [19:0] id; logic [31:0] rs1;
      o = 2'($urandom % 3);
      case ($urandom % 3) 0: id = ID_A; 1: id = ID_B; default: id = ID_X; endcase
      rs1 = (32'($urandom % 18) << 12) | 32'($urandom % 4096);
      shut_err[0] = ($urandom % 3 == 0) ? ($urandom | 32'd1) : 32'd0;
      op(o, 3'($urandom % 8), 25'($urandom), id, rs1, $urandom, 8'(1 + $urandom % 2),
         (o == 2'd0) ? "R1" : (o == 2'd1) ? "R9" : "R7");
    end

    // R12 reset empties the table
    op(2'd0, 3'd0, 25'h0, ID_A, 32'h0, 32'h1, 8'd1, "R1");
    do_reset();
    op(2'd2, 3'd0, 25'h0, 20'h0, 32'h0000_0000, 32'h0, 8'd1, "R12");
    op(2'd0, 3'd0, 25'h0, ID_B, 32'h0, 32'h2, 8'd1, "R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule